// File: doc/BRIEF.md
# Dual Reloadable Down-Counting Timer

The block holds two independent 32-bit down-counters behind a small synchronous register bus. Each counter has its own run and auto-reload controls and its own choice of count source. The source is either an external reference strobe or the system clock divided by a power of two, where the exponent is software programmable. When a counter is already at zero and takes one more count step, it raises its own expiry flag. In periodic mode it then restarts from its reload register. In one-shot mode it parks at zero.

The two expiry flags share one status word. Software clears a flag by writing zero to its bit. A single interrupt line follows the OR of the two flags. A full-range free-running counter is made by loading all-ones into both the value and reload registers with reload on. Software reads elapsed time by inverting the value register.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Register offsets are control 0x00, status 0x04, reload0 0x10, value0 0x14, reload1 0x18, value1 0x1C. Control bits are: run0 bit 0, reload-on0 bit 1, run1 bit 2, reload-on1 bit 3, reference-select0 bit 11, reference-select1 bit 12, divider exponent0 bits 21:19 and divider exponent1 bits 24:22. Unused control bits read zero, so writing all-ones reads back 0x01F8180F.
- R3: A running counter with a nonzero value decreases by exactly one on each count step, and the new value is readable at its value offset.
- R4: With reference-select set, a running counter steps once for each clock cycle in which `ref_tick` is high, and not otherwise.
- R5: With reference-select clear and divider exponent N, a running counter steps once every 2^N clocks. The first step comes 2^N clocks after the run bit is set, because the divider restarts whenever the timer is stopped.
- R6: A step taken while the value is zero sets that timer's expiry flag: status bit 0 for timer 0 and status bit 8 for timer 1.
- R7: In periodic mode the step at zero loads the reload register, and counting continues from there.
- R8: In one-shot mode the step at zero leaves the value at zero. Later steps neither change the value nor set the flag again until the value register is rewritten.
- R9: A bus write to a value register takes effect on that clock edge, even when a count step happens in the same cycle.
- R10: Writing 0 to a status flag bit clears it and writing 1 leaves it unchanged. An expiry in the same cycle wins over the clear.
- R11: `irq` is the OR of the two expiry flags, delayed by one clock.
- R12: A stopped counter keeps its value whatever `ref_tick` or the clock does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| ref_tick | input | 1 | Reference count strobe, one clock wide per tick |
| irq | output | 1 | Registered OR of the expiry flags |

## Verification
On every cycle the assertions check the counter steps: a write wins over a step, a step decrements by one, an idle counter holds its value, an expiry reloads or parks the counter, and a flag sets after an expiry and clears after a zero write. They also check that the interrupt follows a rising flag. Only the bench scenarios can show the exact divider period for each exponent, the reset of the divider when a timer stops, the readback of the control mask, and a full periodic and one-shot cycle seen through the bus. The bench sweeps every divider exponent from 0 to 4 and compares the value register with the step count it computes itself.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_STATUS  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_RELOAD0 = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_VALUE0  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_RELOAD1 = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_VALUE1  = 8'h1C;

  // control field positions for timer t
  function automatic int run_bit(input int t);    return 2 * t;      endfunction
  function automatic int reload_bit(input int t); return 2 * t + 1;  endfunction
  function automatic int refsel_bit(input int t); return 11 + t;     endfunction
  function automatic int div_lsb(input int t);    return 19 + 3 * t; endfunction
  function automatic int flag_bit(input int t);   return 8 * t;      endfunction
endpackage

// File: rtl/dtmr_tick_gen.sv
module dtmr_tick_gen #(
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             use_ref,
  input  logic             ref_tick,
  input  logic [PSC_W-1:0] div_exp,
  output logic             step
);
  localparam int DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] pcnt;

  // terminal count: the low div_exp bits are all ones
  function automatic logic psc_hit(input logic [DIV_W-1:0] c, input logic [PSC_W-1:0] n);
    logic [DIV_W:0] mask;
    mask = ({{DIV_W{1'b0}}, 1'b1} << n) - 1'b1;
    return ({1'b0, c} & mask) == mask;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt <= '0;
    else if (!enable) pcnt <= '0;
    else              pcnt <= pcnt + 1'b1;
  end

  assign step = enable & (use_ref ? ref_tick : psc_hit(pcnt, div_exp));
endmodule

// File: rtl/dtmr_counter.sv
module dtmr_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          reload_en,
  input  logic [CW-1:0] reload_val,
  input  logic          wr_val,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] cnt,
  output logic          expire
);
  logic armed;
  logic at_zero;

  assign at_zero = (cnt == '0);
  assign expire  = step & armed & at_zero & ~wr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (wr_val) begin
      cnt   <= wr_data;
      armed <= 1'b1;
    end else if (expire) begin
      if (reload_en) cnt <= reload_val;
      armed <= reload_en;
    end else if (step && armed) begin
      cnt <= cnt - 1'b1;
    end
  end

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_val |=> cnt == $past(wr_data)); // R9
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_val && cnt != '0) |=> cnt == $past(cnt) - 1'b1); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !wr_val) |=> $stable(cnt)); // R12
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && reload_en) |=> cnt == $past(reload_val)); // R7
  AST_ONESHOT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !reload_en) |=> (cnt == '0 && !armed)); // R8
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer #(
  parameter int CW    = 32,
  parameter int PSC_W = 3,
  parameter int N_TMR = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        ref_tick,
  output logic        irq
);
  import dtmr_pkg::*;

  logic [31:0] ctrl_q;
  logic [31:0] ctrl_mask;
  logic [N_TMR-1:0] flag_q;
  logic [N_TMR-1:0] expire_w;
  logic [CW-1:0] reload_q [N_TMR];
  logic [CW-1:0] cnt_w    [N_TMR];
  logic [31:0] status_w;

  always_comb begin
    ctrl_mask = '0;
    status_w  = '0;
    for (int t = 0; t < N_TMR; t++) begin
      ctrl_mask[run_bit(t)]    = 1'b1;
      ctrl_mask[reload_bit(t)] = 1'b1;
      ctrl_mask[refsel_bit(t)] = 1'b1;
      for (int b = 0; b < PSC_W; b++) ctrl_mask[div_lsb(t) + b] = 1'b1;
      status_w[flag_bit(t)] = flag_q[t];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            ctrl_q <= '0;
    else if (bus_wr && bus_addr == OFS_CTRL) ctrl_q <= bus_wdata & ctrl_mask;
  end

  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    localparam logic [7:0] RLD_OFS = OFS_RELOAD0 + 8'(8 * t);
    localparam logic [7:0] VAL_OFS = OFS_VALUE0 + 8'(8 * t);
    logic step_w;
    logic wr_val_w;
    logic clr_w;

    assign wr_val_w = bus_wr && bus_addr == VAL_OFS;
    assign clr_w    = bus_wr && bus_addr == OFS_STATUS && !bus_wdata[flag_bit(t)];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           reload_q[t] <= '0;
      else if (bus_wr && bus_addr == RLD_OFS) reload_q[t] <= bus_wdata[CW-1:0];
    end

    dtmr_tick_gen #(.PSC_W(PSC_W)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (ctrl_q[run_bit(t)]),
      .use_ref  (ctrl_q[refsel_bit(t)]),
      .ref_tick (ref_tick),
      .div_exp  (ctrl_q[div_lsb(t) +: PSC_W]),
      .step     (step_w)
    );

    dtmr_counter #(.CW(CW)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .step       (step_w),
      .reload_en  (ctrl_q[reload_bit(t)]),
      .reload_val (reload_q[t]),
      .wr_val     (wr_val_w),
      .wr_data    (bus_wdata[CW-1:0]),
      .cnt        (cnt_w[t]),
      .expire     (expire_w[t])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flag_q[t] <= 1'b0;
      else if (expire_w[t]) flag_q[t] <= 1'b1;
      else if (clr_w)       flag_q[t] <= 1'b0;
    end

    AST_FLAG_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
      expire_w[t] |=> flag_q[t]); // R6
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_w && !expire_w[t]) |=> !flag_q[t]); // R10
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |flag_q;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL:    bus_rdata = ctrl_q;
      OFS_STATUS:  bus_rdata = status_w;
      OFS_RELOAD0: bus_rdata = 32'(reload_q[0]);
      OFS_VALUE0:  bus_rdata = 32'(cnt_w[0]);
      OFS_RELOAD1: bus_rdata = 32'(reload_q[N_TMR-1]);
      OFS_VALUE1:  bus_rdata = 32'(cnt_w[N_TMR-1]);
      default:     bus_rdata = '0;
    endcase
  end

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|flag_q) |=> irq); // R11
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|flag_q) |=> !irq); // R11
endmodule

// File: tb/dual_reload_timer_tb.sv
module dual_reload_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ref_tick = 1'b0;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_reload_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ref_tick(ref_tick), .irq(irq)
  );

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_chk("R1 ctrl", 8'h00, 0);
    rd_chk("R1 status", 8'h04, 0);
    rd_chk("R1 reload0", 8'h10, 0);
    rd_chk("R1 value0", 8'h14, 0);
    rd_chk("R1 reload1", 8'h18, 0);
    rd_chk("R1 value1", 8'h1C, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R2 control mask and register offsets
    wr(8'h00, 32'hFFFF_FFFF);
    rd_chk("R2 ctrl mask", 8'h00, 32'h01F8_180F);
    wr(8'h00, 0);
    wr(8'h10, 32'h1111_0000);
    wr(8'h18, 32'h2222_0000);
    rd_chk("R2 reload0", 8'h10, 32'h1111_0000);
    rd_chk("R2 reload1", 8'h18, 32'h2222_0000);

    // R3 R4 reference tick counting on timer 0
    wr(8'h14, 32'd5);
    wr(8'h00, 32'h0000_0801);
    ticks(3);
    rd_chk("R3 R4 value after 3 ticks", 8'h14, 32'd2);
    repeat (6) @(negedge clk);
    rd_chk("R4 no tick no step", 8'h14, 32'd2);

    // R12 stopped counter holds
    wr(8'h00, 0);
    ticks(2);
    rd_chk("R12 stopped hold", 8'h14, 32'd2);

    // R5 divider sweep on timer 1
    for (int n = 0; n <= 4; n++) begin
      for (int c = 1; c <= 40; c += 13) begin
        wr(8'h00, 0);
        wr(8'h1C, 32'd1000);
        wr(8'h00, 32'h4 | (n << 22));
        repeat (c) @(posedge clk);
        @(negedge clk);
        rd_chk($sformatf("R5 n=%0d c=%0d", n, c), 8'h1C, 32'd1000 - (c >> n));
      end
    end
    wr(8'h00, 0);

    // R6 R7 R11 periodic expiry on timer 0
    wr(8'h10, 32'd2);
    wr(8'h14, 32'd1);
    wr(8'h00, 32'h0000_0803);
    ticks(1);
    rd_chk("R3 value 0", 8'h14, 0);
    rd_chk("R6 no flag yet", 8'h04, 0);
    @(negedge clk); ref_tick = 1'b1;
    @(negedge clk); ref_tick = 1'b0;
    rd_chk("R7 reloaded", 8'h14, 32'd2);
    rd_chk("R6 flag bit0", 8'h04, 32'h1);
    chk("R11 irq delayed", {31'd0, irq}, 0);
    @(negedge clk);
    chk("R11 irq high", {31'd0, irq}, 1);
    ticks(2);
    rd_chk("R7 continues", 8'h14, 0);
    wr(8'h00, 0);

    // R10 flag clearing
    wr(8'h04, 32'hFFFF_FFFF);
    rd_chk("R10 write one keeps", 8'h04, 32'h1);
    wr(8'h04, 32'hFFFF_FFFE);
    rd_chk("R10 write zero clears", 8'h04, 0);
    chk("R11 irq still high", {31'd0, irq}, 1);
    @(negedge clk);
    chk("R11 irq low", {31'd0, irq}, 0);

    // R8 one-shot on timer 1
    wr(8'h1C, 32'd1);
    wr(8'h00, 32'h0000_1004);
    ticks(2);
    rd_chk("R8 parked", 8'h1C, 0);
    rd_chk("R6 flag bit8", 8'h04, 32'h100);
    wr(8'h04, 0);
    ticks(3);
    rd_chk("R8 stays zero", 8'h1C, 0);
    rd_chk("R8 no re-flag", 8'h04, 0);
    wr(8'h00, 0);

    // R9 write beats a step in the same cycle
    wr(8'h14, 32'd50);
    wr(8'h00, 32'h0000_0801);
    @(negedge clk);
    ref_tick = 1'b1; bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'd7;
    @(negedge clk);
    ref_tick = 1'b0; bus_wr = 1'b0;
    rd_chk("R9 write priority", 8'h14, 32'd7);

    // R7 full-range free run
    wr(8'h00, 0);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h00, 32'h0000_0803);
    ticks(4);
    rd_chk("R7 free run", 8'h14, 32'hFFFF_FFFB);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule